// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial target engine and a non-volatile storage array. It holds a 15-bit address counter, shared by reads and writes. A write sequence loads the address and then sends data bytes. The block stores each byte in a 64-entry page buffer at the counter's low six bits. It then steps only those low bits, so the page number never changes and a long burst wraps back over earlier offsets.

When the serial engine reports a stop, and at least one byte has been buffered, the block starts a self-timed write cycle. A counter first runs for a programmable number of clocks. Then the buffer is walked in ascending offset order, and only the offsets that were actually written are emitted to the array. For the whole cycle `busy` is high and every bus event is ignored. The serial engine uses `busy` to withhold the acknowledge of its device address, which is how acknowledge polling works.

A sequence that ends in a repeated start discards any buffered bytes and keeps the loaded address. This is what a dummy write before a random read needs. Read advances step the full 15-bit counter and wrap at the top of the memory.

Top module: `page_commit_buf`

## Requirements
- R1: After synchronous reset, `busy` is 0, `cur_addr` is 0 and `mem_we` is 0.
- R2: An `addr_load` pulse while idle sets `cur_addr` to `load_addr` one clock later.
- R3: Each `wr_byte` pulse while idle adds one to `cur_addr[5:0]` modulo 64 and leaves `cur_addr[14:6]` (the page) unchanged, so offset 63 is followed by offset 0 of the same page.
- R4: When more than 64 bytes are written in one sequence, the byte committed at each offset is the last one written there.
- R5: A `seq_stop` pulse while idle, with at least one byte buffered, raises `busy` one clock later. `busy` then stays high for exactly `WR_CYCLES + 64` clocks.
- R6: A `seq_stop` with no byte buffered, or a `seq_restart`, starts no write cycle and produces no array write. A `seq_restart` discards the buffered bytes but keeps `cur_addr`.
- R7: While `busy` is high, `addr_load`, `wr_byte`, `rd_adv`, `seq_stop` and `seq_restart` have no effect. `cur_addr` stays unchanged, and bytes offered then are never written.
- R8: A commit writes each buffered offset exactly once, in ascending offset order, at address {page, offset}, and only while `busy` is high. Unwritten offsets of the page get no write.
- R9: After a commit, `cur_addr` equals the page with the offset one past the last byte written, modulo 64.
- R10: An `rd_adv` pulse while idle adds one to the whole 15-bit `cur_addr`, and 0x7FFF goes to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the address counter from `load_addr` |
| load_addr | input | 15 | Address received by the serial engine |
| wr_byte | input | 1 | One data byte received in a write sequence |
| wr_data | input | 8 | Data byte for `wr_byte` |
| rd_adv | input | 1 | Read byte delivered; advance address over the whole memory |
| seq_stop | input | 1 | Stop condition ended the sequence |
| seq_restart | input | 1 | Repeated start ended the sequence |
| busy | output | 1 | Write cycle running; engine must not acknowledge |
| cur_addr | output | 15 | Current address counter |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach from the ports is a burst longer than one page that begins near the end of a page. Here the wrapped offsets and overwritten bytes must show up in the commit stream in ascending order, not in arrival order. The bench starts one burst at offset 62 and sends another of 66 bytes from offset 0. It then compares every captured array write against the expected offset order and last-written data. A second hard case is bus activity during the write cycle. The bench fires loads, bytes and read advances while `busy` is high and confirms that neither the counter nor the commit stream changes.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int ADDR_W     = 15;
    localparam int OFF_W      = 6;
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int DATA_W     = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_HOLD  = 2'd1,
        CYC_FLUSH = 2'd2
    } cyc_state_t;

    // bus events after gating by busy
    typedef struct packed {
        logic ld;
        logic wr;
        logic adv;
        logic stop;
        logic abort;
    } bus_ev_t;

    function automatic addr_t step_in_page(addr_t a);
        off_t o;
        o = a[OFF_W-1:0] + off_t'(1);
        return {a[ADDR_W-1:OFF_W], o};
    endfunction
endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr
    import pcb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  addr_t   load_val,
    output addr_t   addr
);
    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (ev.ld)   addr <= load_val;
        else if (ev.wr)   addr <= step_in_page(addr);
        else if (ev.adv)  addr <= addr + addr_t'(1);
    end

    // R3: a byte write never moves the page bits
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (rst)
        (ev.wr && !ev.ld) |=> addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W]));

    // R10: a read advance at the top of memory wraps to zero
    a_r10_full_wrap: assert property (@(posedge clk) disable iff (rst)
        (ev.adv && !ev.ld && !ev.wr && addr == '1) |=> addr == '0);
endmodule

// File: rtl/pcb_page_buf.sv
module pcb_page_buf
    import pcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  off_t  wr_off,
    input  byte_t wr_val,
    input  logic  clr,
    input  off_t  rd_off,
    output byte_t rd_val,
    output logic  rd_mark,
    output logic  any_mark
);
    byte_t                 lane [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr && wr_off == off_t'(g)) lane[g] <= wr_val;
        end
        always_ff @(posedge clk) begin
            if (rst || clr)                     mark[g] <= 1'b0;
            else if (wr && wr_off == off_t'(g)) mark[g] <= 1'b1;
        end
    end

    assign rd_val   = lane[rd_off];
    assign rd_mark  = mark[rd_off];
    assign any_mark = |mark;

    // R6: a clear leaves nothing buffered
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_mark);

    // R4: a write always leaves its offset marked
    a_r4_write_marks: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> mark[$past(wr_off)]);
endmodule

// File: rtl/pcb_commit_seq.sv
module pcb_commit_seq
    import pcb_pkg::*;
#(
    parameter int WR_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic flush,
    output off_t idx,
    output logic done
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);
    localparam off_t IDX_LAST = off_t'(PAGE_BYTES - 1);

    cyc_state_t       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CYC_IDLE;
            cnt <= '0;
            idx <= '0;
        end else begin
            unique case (st)
                CYC_IDLE: if (start) begin
                    st  <= CYC_HOLD;
                    cnt <= '0;
                end
                CYC_HOLD: if (cnt == CNT_LAST) begin
                    st  <= CYC_FLUSH;
                    idx <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                CYC_FLUSH: if (idx == IDX_LAST) st <= CYC_IDLE;
                           else                 idx <= idx + 1'b1;
                default: st <= CYC_IDLE;
            endcase
        end
    end

    assign busy  = (st != CYC_IDLE);
    assign flush = (st == CYC_FLUSH);
    assign done  = flush && (idx == IDX_LAST);

    // R8: the flush walk visits offsets in ascending order
    a_r8_ascending: assert property (@(posedge clk) disable iff (rst)
        (flush && !done) |=> flush && idx == $past(idx) + off_t'(1));

    // R5: once started, the cycle cannot end before the walk completes
    a_r5_ends_after_walk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pcb_pkg::*;
#(
    parameter int WR_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    input  logic              seq_stop,
    input  logic              seq_restart,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    bus_ev_t ev;
    addr_t   addr;
    page_t   page_q;
    logic    start, flush, done, rd_mark, any_mark;
    off_t    idx;
    byte_t   rd_val;

    // every bus event is dropped while the write cycle runs
    always_comb begin
        ev.ld    = addr_load   && !busy;
        ev.wr    = wr_byte     && !busy;
        ev.adv   = rd_adv      && !busy;
        ev.stop  = seq_stop    && !busy;
        ev.abort = seq_restart && !busy;
    end

    assign start = ev.stop && any_mark;

    pcb_addr_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .load_val (load_addr),
        .addr     (addr)
    );

    pcb_page_buf u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr       (ev.wr && !ev.ld),
        .wr_off   (addr[OFF_W-1:0]),
        .wr_val   (wr_data),
        .clr      (ev.abort || done),
        .rd_off   (idx),
        .rd_val   (rd_val),
        .rd_mark  (rd_mark),
        .any_mark (any_mark)
    );

    pcb_commit_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .flush (flush),
        .idx   (idx),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst)        page_q <= '0;
        else if (start) page_q <= addr[ADDR_W-1:OFF_W];
    end

    assign cur_addr  = addr;
    assign mem_we    = flush && rd_mark;
    assign mem_addr  = {page_q, idx};
    assign mem_wdata = rd_val;

    // R5: a stop with buffered data opens the write cycle
    a_r5_stop_starts: assert property (@(posedge clk) disable iff (rst)
        (seq_stop && !busy && any_mark) |=> busy);

    // R6: a stop with nothing buffered opens nothing
    a_r6_empty_stop: assert property (@(posedge clk) disable iff (rst)
        (seq_stop && !busy && !any_mark && !seq_restart) |=> !busy);

    // R7: the counter is frozen across busy cycles
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_addr));

    // R8: array writes only happen inside the busy window
    a_r8_we_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);
endmodule

// File: tb/page_commit_buf_test.sv
module page_commit_buf_test;
    localparam int WR = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 1'b0, wr_byte = 1'b0, rd_adv = 1'b0;
    logic        seq_stop = 1'b0, seq_restart = 1'b0;
    logic [14:0] load_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, mem_we;
    logic [14:0] cur_addr, mem_addr;
    logic [7:0]  mem_wdata;

    always #2.5 clk = ~clk;

    page_commit_buf #(.WR_CYCLES(WR)) uut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .load_addr(load_addr),
        .wr_byte(wr_byte), .wr_data(wr_data), .rd_adv(rd_adv),
        .seq_stop(seq_stop), .seq_restart(seq_restart), .busy(busy),
        .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    int errors = 0;
    int checks = 0;

    logic [14:0] cap_a [512];
    logic [7:0]  cap_d [512];
    int          cap_n = 0;

    always @(posedge clk) begin
        if (mem_we && cap_n < 512) begin
            cap_a[cap_n] <= mem_addr;
            cap_d[cap_n] <= mem_wdata;
            cap_n        <= cap_n + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(int a);
        addr_load = 1'b1; load_addr = 15'(a);
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic do_write(int d);
        wr_byte = 1'b1; wr_data = 8'(d);
        @(negedge clk);
        wr_byte = 1'b0;
    endtask

    task automatic do_adv();
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
    endtask

    task automatic do_stop();
        seq_stop = 1'b1;
        @(negedge clk);
        seq_stop = 1'b0;
    endtask

    task automatic do_restart();
        seq_restart = 1'b1;
        @(negedge clk);
        seq_restart = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 cur_addr after reset", int'(cur_addr), 0);
        chk("R1 mem_we after reset", int'(mem_we), 0);
    endtask

    task automatic t_load_adv();
        do_load(32766);
        chk("R2 load", int'(cur_addr), 32766);
        do_adv();
        chk("R10 advance", int'(cur_addr), 32767);
        do_adv();
        chk("R10 top wrap", int'(cur_addr), 0);
    endtask

    task automatic t_byte_write();
        int n, base;
        do_load(330);
        do_write(8'hA1); do_write(8'hA2); do_write(8'hA3);
        chk("R3 offset step", int'(cur_addr), 333);
        base = cap_n;
        do_stop();
        wait_idle(n);
        chk("R5 busy length", n, WR + 64);
        chk("R8 write count", cap_n - base, 3);
        chk("R8 first addr", int'(cap_a[base]), 330);
        chk("R8 first data", int'(cap_d[base]), 8'hA1);
        chk("R8 last addr", int'(cap_a[base+2]), 332);
        chk("R8 last data", int'(cap_d[base+2]), 8'hA3);
        chk("R9 addr after commit", int'(cur_addr), 333);
    endtask

    task automatic t_wrap();
        int n, base;
        do_load(7 * 64 + 62);
        do_write(8'h10); do_write(8'h11); do_write(8'h12); do_write(8'h13);
        chk("R3 page wrap", int'(cur_addr), 7 * 64 + 2);
        base = cap_n;
        do_stop();
        wait_idle(n);
        chk("R8 wrap count", cap_n - base, 4);
        chk("R8 order a0", int'(cap_a[base]),   448);
        chk("R8 order d0", int'(cap_d[base]),   8'h12);
        chk("R8 order a1", int'(cap_a[base+1]), 449);
        chk("R8 order a2", int'(cap_a[base+2]), 510);
        chk("R8 order d2", int'(cap_d[base+2]), 8'h10);
        chk("R8 order d3", int'(cap_d[base+3]), 8'h11);
        chk("R9 addr after wrap commit", int'(cur_addr), 450);
    endtask

    task automatic t_overwrite();
        int n, base;
        do_load(192);
        for (int i = 0; i < 66; i++) do_write(i);
        base = cap_n;
        do_stop();
        wait_idle(n);
        chk("R4 full page count", cap_n - base, 64);
        chk("R4 offset0 addr", int'(cap_a[base]), 192);
        chk("R4 offset0 data", int'(cap_d[base]), 64);
        chk("R4 offset1 data", int'(cap_d[base+1]), 65);
        chk("R4 offset5 data", int'(cap_d[base+5]), 5);
        chk("R4 offset63 addr", int'(cap_a[base+63]), 255);
        chk("R9 addr after overwrite", int'(cur_addr), 194);
    endtask

    task automatic t_no_commit();
        int base;
        base = cap_n;
        do_load(1000);
        do_stop();
        chk("R6 empty stop busy", int'(busy), 0);
        do_load(2000);
        do_write(8'h55); do_write(8'h66);
        do_restart();
        chk("R6 restart busy", int'(busy), 0);
        chk("R6 restart keeps addr", int'(cur_addr), 2002);
        do_stop();
        chk("R6 stop after restart busy", int'(busy), 0);
        repeat (WR + 70) @(negedge clk);
        chk("R6 no array writes", cap_n - base, 0);
    endtask

    task automatic t_busy_ignore();
        int n, base;
        do_load(9 * 64 + 4);
        do_write(8'h3C);
        base = cap_n;
        do_stop();
        do_load(100);
        do_write(8'hEE);
        do_adv();
        do_restart();
        do_stop();
        chk("R7 addr frozen", int'(cur_addr), 581);
        wait_idle(n);
        chk("R7 only one write", cap_n - base, 1);
        chk("R7 write addr", int'(cap_a[base]), 580);
        chk("R7 write data", int'(cap_d[base]), 8'h3C);
        chk("R7 addr after", int'(cur_addr), 581);
        do_stop();
        chk("R7 late byte not buffered", int'(busy), 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog R1..: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load_adv();
        t_byte_write();
        t_wrap();
        t_overwrite();
        t_no_commit();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule